// File: doc/BRIEF.md
# Configurable GPIO Port with Pin Interrupts

This block controls a port of general-purpose pins. Each pin's three-bit drive mode is set through three separate mode registers, one bit per register at the pin's own bit position. The block decodes each mode and the pin's output-data bit into abstract pad controls:

- strong-high and strong-low drive enables
- pull-up and pull-down enables
- a slow-edge flag
- an input-buffer enable

Pin inputs pass through a two-flop synchronizer. The synchronized values are then masked by the input-buffer enable, and this masked view is what reads and interrupt logic see.

Each pin has a two-bit interrupt mode, split across two control registers at the pin's bit position, and an interrupt-enable bit. A pin can request an interrupt in three ways: while it is low, while it is high, or while it differs from a read latch. The read latch is reloaded every time software reads the data register. All pin requests are ORed into one level-sensitive port interrupt.

Software reaches the registers through a request channel (valid/ready) and a read-response channel (valid/ready):

- A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- A write takes effect at that edge and returns no response.
- A read returns one response, registered at the accepting edge.
- The response holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is seen high.
- While a response waits, `req_ready` is low, so no new request is accepted.

Top module: `gpio_port`

## Requirements

- R1: After reset, every pin is in mode 110b, since the DM1 and DM2 registers read 8'hFF. All other registers read 0. Every pad control output is 0 and `irq` is 0.
- R2: Register addresses are 0 data, 1 DM0, 2 DM1, 3 DM2, 4 IC0, 5 IC1 and 6 IE. A write to addresses 1 to 6 is read back unchanged. A write to address 0 sets the output-data bits. A read of address 0 returns the masked pin view.
- R3: Drive decode of mode {DM2,DM1,DM0} with data bit d. Unlisted cases leave every control off.
  - 000: d=1 drive high, d=0 pull down.
  - 001: d drives high or low.
  - 010: no drive.
  - 011: d=1 pull up, d=0 drive low.
  - 100: d=1 drive high.
  - 101: d drives high or low.
  - 110: no drive.
  - 111: d=0 drive low.
- R4: The slow-edge flag is set in modes 100, 101 and 111. The input enable is set in every mode except 110. No pin ever has drive-high and drive-low together.
- R5: A pin in mode 110 reads as 0 and never contributes to `irq`.
- R6: Interrupt mode {IC1,IC0} = 00 keeps the pin's request low even when its IE bit is 1.
- R7: Mode 01 requests while the pin is low. Mode 10 requests while the pin is high. Both need the pin's IE bit to be 1.
- R8: Mode 11 requests while the pin differs from its read-latch bit.
- R9: Every accepted read of address 0 loads the read latch with the value returned. With the pin steady, this clears a mode-11 request.
- R10: A pin change reaches `irq` two clock edges after it is applied, and no earlier.
- R11: `irq` is the OR of all pin requests. It drops as soon as no request remains.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low. `rsp_valid` and `rsp_rdata` also hold.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | PINS | Raw pin levels |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register address |
| req_wdata | input | PINS | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | PINS | Read data |
| pad_drv_hi | output | PINS | Strong-high drive enable per pin |
| pad_drv_lo | output | PINS | Strong-low drive enable per pin |
| pad_pull_up | output | PINS | Pull-up enable per pin |
| pad_pull_dn | output | PINS | Pull-down enable per pin |
| pad_slow | output | PINS | Slow-edge flag per pin |
| pad_in_en | output | PINS | Input-buffer enable per pin |
| irq | output | 1 | Port interrupt, level |

## Verification

The assertions assume that `rst` is held for at least one edge. They also assume the response consumer may stall for any number of cycles, but that requests are otherwise free-running. Beyond that, the checks rest only on what the design drives.

The bench changes pins only at falling edges and never mid-request. It holds `rsp_ready` high except in the deliberate stall test. It always waits for `req_ready` before raising a request, so every handshake it makes is legal under the channel rules.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    RA_DATA = 3'd0,
    RA_DM0  = 3'd1,
    RA_DM1  = 3'd2,
    RA_DM2  = 3'd3,
    RA_IC0  = 3'd4,
    RA_IC1  = 3'd5,
    RA_IE   = 3'd6,
    RA_NONE = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic hi;
    logic lo;
    logic pu;
    logic pd;
    logic slow;
    logic ien;
  } pad_ctl_t;

  // Decode one pin's mode and output-data bit into pad controls.
  function automatic pad_ctl_t decode_drive(input logic [2:0] mode, input logic d);
    pad_ctl_t c;
    c = '0;
    c.ien = (mode != 3'b110);
    unique case (mode)
      3'b000: begin c.hi = d;  c.pd = ~d; end
      3'b001: begin c.hi = d;  c.lo = ~d; end
      3'b011: begin c.pu = d;  c.lo = ~d; end
      3'b100: begin c.hi = d;  c.slow = 1'b1; end
      3'b101: begin c.hi = d;  c.lo = ~d; c.slow = 1'b1; end
      3'b111: begin c.lo = ~d; c.slow = 1'b1; end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_drive_dec.sv
module gpio_drive_dec
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] dm0,
  input  logic [W-1:0] dm1,
  input  logic [W-1:0] dm2,
  input  logic [W-1:0] dout,
  output logic [W-1:0] drv_hi,
  output logic [W-1:0] drv_lo,
  output logic [W-1:0] pull_up,
  output logic [W-1:0] pull_dn,
  output logic [W-1:0] slow,
  output logic [W-1:0] in_en
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pad_ctl_t c;
    always_comb c = decode_drive({dm2[i], dm1[i], dm0[i]}, dout[i]);
    assign drv_hi[i]  = c.hi;
    assign drv_lo[i]  = c.lo;
    assign pull_up[i] = c.pu;
    assign pull_dn[i] = c.pd;
    assign slow[i]    = c.slow;
    assign in_en[i]   = c.ien;
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 8
) (
  input  logic [W-1:0] pin_view,
  input  logic [W-1:0] in_en,
  input  logic [W-1:0] ic0,
  input  logic [W-1:0] ic1,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] rlatch,
  output logic [W-1:0] pin_req,
  output logic         irq
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic cond;
    always_comb begin
      unique case ({ic1[i], ic0[i]})
        2'b01:   cond = ~pin_view[i];
        2'b10:   cond = pin_view[i];
        2'b11:   cond = pin_view[i] ^ rlatch[i];
        default: cond = 1'b0;
      endcase
    end
    assign pin_req[i] = cond & ien[i] & in_en[i];
  end

  assign irq = |pin_req;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pin_in,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PINS-1:0]   req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PINS-1:0]   rsp_rdata,
  output logic [PINS-1:0]   pad_drv_hi,
  output logic [PINS-1:0]   pad_drv_lo,
  output logic [PINS-1:0]   pad_pull_up,
  output logic [PINS-1:0]   pad_pull_dn,
  output logic [PINS-1:0]   pad_slow,
  output logic [PINS-1:0]   pad_in_en,
  output logic              irq
);
  localparam logic [PINS-1:0] ALL_ONES = {PINS{1'b1}};

  logic [PINS-1:0] dout_q, dm0_q, dm1_q, dm2_q, ic0_q, ic1_q, ie_q;
  logic [PINS-1:0] rlatch_q, pin_sync, pin_view, rd_mux, pin_req;
  logic            accept, do_wr, do_rd;
  reg_addr_e       addr;

  assign addr      = reg_addr_e'(req_addr[2:0]);
  assign req_ready = !(rsp_valid && !rsp_ready);
  assign accept    = req_valid && req_ready;
  assign do_wr     = accept && req_write;
  assign do_rd     = accept && !req_write;

  gpio_sync #(.W(PINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  gpio_drive_dec #(.W(PINS)) u_dec (
    .dm0     (dm0_q),
    .dm1     (dm1_q),
    .dm2     (dm2_q),
    .dout    (dout_q),
    .drv_hi  (pad_drv_hi),
    .drv_lo  (pad_drv_lo),
    .pull_up (pad_pull_up),
    .pull_dn (pad_pull_dn),
    .slow    (pad_slow),
    .in_en   (pad_in_en)
  );

  assign pin_view = pin_sync & pad_in_en;

  gpio_irq #(.W(PINS)) u_irq (
    .pin_view (pin_view),
    .in_en    (pad_in_en),
    .ic0      (ic0_q),
    .ic1      (ic1_q),
    .ien      (ie_q),
    .rlatch   (rlatch_q),
    .pin_req  (pin_req),
    .irq      (irq)
  );

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dm0_q  <= '0;
      dm1_q  <= ALL_ONES;
      dm2_q  <= ALL_ONES;
      ic0_q  <= '0;
      ic1_q  <= '0;
      ie_q   <= '0;
    end else if (do_wr) begin
      unique case (addr)
        RA_DATA: dout_q <= req_wdata;
        RA_DM0:  dm0_q  <= req_wdata;
        RA_DM1:  dm1_q  <= req_wdata;
        RA_DM2:  dm2_q  <= req_wdata;
        RA_IC0:  ic0_q  <= req_wdata;
        RA_IC1:  ic1_q  <= req_wdata;
        RA_IE:   ie_q   <= req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      RA_DATA: rd_mux = pin_view;
      RA_DM0:  rd_mux = dm0_q;
      RA_DM1:  rd_mux = dm1_q;
      RA_DM2:  rd_mux = dm2_q;
      RA_IC0:  rd_mux = ic0_q;
      RA_IC1:  rd_mux = ic1_q;
      RA_IE:   rd_mux = ie_q;
      default: rd_mux = '0;
    endcase
  end

  // Read latch follows every accepted data-register read
  always_ff @(posedge clk) begin
    if (rst)
      rlatch_q <= '0;
    else if (do_rd && addr == RA_DATA)
      rlatch_q <= pin_view;
  end

  // Response channel
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (do_rd) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PINS = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PINS-1:0] rsp_rdata,
  input logic [PINS-1:0] pad_drv_hi,
  input logic [PINS-1:0] pad_drv_lo,
  input logic [PINS-1:0] pad_pull_up,
  input logic [PINS-1:0] pad_pull_dn,
  input logic [PINS-1:0] pad_in_en,
  input logic            irq
);
  a_r12_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r4_no_fight: assert property (@(posedge clk) disable iff (rst)
    ((pad_drv_hi & pad_drv_lo) == '0) && ((pad_pull_up & pad_pull_dn) == '0));

  a_r5_no_input_no_irq: assert property (@(posedge clk) disable iff (rst)
    (pad_in_en == '0) |-> !irq);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_in_en == '0 && pad_drv_hi == '0 && pad_drv_lo == '0 && !irq && !rsp_valid));
endmodule

bind gpio_port gpio_port_chk #(.PINS(PINS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_rdata   (rsp_rdata),
  .pad_drv_hi  (pad_drv_hi),
  .pad_drv_lo  (pad_drv_lo),
  .pad_pull_up (pad_pull_up),
  .pad_pull_dn (pad_pull_dn),
  .pad_in_en   (pad_in_en),
  .irq         (irq)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin_in = '0;
  logic       req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, irq;
  logic [7:0] rsp_rdata, pad_drv_hi, pad_drv_lo, pad_pull_up, pad_pull_dn, pad_slow, pad_in_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pad_drv_hi(pad_drv_hi), .pad_drv_lo(pad_drv_lo), .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn), .pad_slow(pad_slow), .pad_in_en(pad_in_en), .irq(irq)
  );

  // {mode[2:0], d, hi, lo, pu, pd, slow, ien}
  localparam logic [9:0] DRV_TAB [16] = '{
    10'b000_0_000101, 10'b000_1_100001, 10'b001_0_010001, 10'b001_1_100001,
    10'b010_0_000001, 10'b010_1_000001, 10'b011_0_010001, 10'b011_1_001001,
    10'b100_0_000011, 10'b100_1_100011, 10'b101_0_010011, 10'b101_1_100011,
    10'b110_0_000000, 10'b110_1_000000, 10'b111_0_010011, 10'b111_1_000011
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 pad_in_en", pad_in_en, 8'h00);
    check("R1 drive", {pad_drv_hi, pad_drv_lo, pad_pull_up, pad_pull_dn}, 32'h0);
    check("R1 irq", irq, 0);
    rd(3'd2, v); check("R1 DM1", v, 8'hFF);
    rd(3'd3, v); check("R1 DM2", v, 8'hFF);
    rd(3'd1, v); check("R1 DM0", v, 8'h00);
    rd(3'd6, v); check("R1 IE", v, 8'h00);

    // R3 R4 drive-decode table applied to all pins at once
    for (int k = 0; k < 16; k++) begin
      logic [9:0] e;
      e = DRV_TAB[k];
      wr(3'd1, {8{e[7]}});
      wr(3'd2, {8{e[8]}});
      wr(3'd3, {8{e[9]}});
      wr(3'd0, {8{e[6]}});
      check("R3 drv_hi",  pad_drv_hi,  {8{e[5]}});
      check("R3 drv_lo",  pad_drv_lo,  {8{e[4]}});
      check("R3 pull_up", pad_pull_up, {8{e[3]}});
      check("R3 pull_dn", pad_pull_dn, {8{e[2]}});
      check("R4 slow",    pad_slow,    {8{e[1]}});
      check("R4 in_en",   pad_in_en,   {8{e[0]}});
    end

    // R2 readback of config registers
    wr(3'd4, 8'h5A); rd(3'd4, v); check("R2 IC0", v, 8'h5A);
    wr(3'd5, 8'hC3); rd(3'd5, v); check("R2 IC1", v, 8'hC3);
    wr(3'd6, 8'h81); rd(3'd6, v); check("R2 IE", v, 8'h81);

    // R5 mode 110 hides pin and blocks irq
    wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd4, 8'h00); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    pin_in = 8'hFF; settle();
    rd(3'd0, v); check("R5 read zero", v, 8'h00);
    check("R5 no irq", irq, 0);

    // Switch to mode 010 (input enabled)
    wr(3'd3, 8'h00);
    pin_in = 8'h3C; settle();
    rd(3'd0, v); check("R2 data read", v, 8'h3C);

    // R6 mode 00 with enable set
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'hFF);
    settle(); check("R6 mode00 quiet", irq, 0);

    // R10 sync latency: pin0 high-level only
    wr(3'd6, 8'h01); wr(3'd5, 8'h01);
    pin_in = 8'h00; settle();
    check("R10 before", irq, 0);
    pin_in = 8'h01;
    @(negedge clk); check("R10 after one edge", irq, 0);
    @(negedge clk); check("R10 after two edges", irq, 1);

    // R7 low mode, enable gating; R11 OR across pins and drop
    wr(3'd5, 8'h00); wr(3'd4, 8'hFF); wr(3'd6, 8'hFF);
    pin_in = 8'hFF; settle(); check("R7 low mode idle", irq, 0);
    pin_in = 8'hFE; settle(); check("R7 low mode fire", irq, 1);
    wr(3'd6, 8'hFE); @(negedge clk); check("R7 enable off", irq, 0);
    wr(3'd6, 8'hFF); pin_in = 8'h7F; settle(); check("R11 other pin", irq, 1);
    pin_in = 8'hFF; settle(); check("R11 drop", irq, 0);

    // R8 R9 change mode against read latch
    wr(3'd5, 8'hFF);
    pin_in = 8'h00; settle();
    rd(3'd0, v); @(negedge clk); check("R9 latch 0 quiet", irq, 0);
    pin_in = 8'h10; settle(); check("R8 differs high", irq, 1);
    rd(3'd0, v); check("R9 read value", v, 8'h10);
    @(negedge clk); check("R9 read clears", irq, 0);
    pin_in = 8'h00; settle(); check("R8 differs low", irq, 1);
    rd(3'd0, v); @(negedge clk); check("R9 clears again", irq, 0);

    // R12 back-pressure
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 3'd6;
    @(negedge clk);
    req_valid = 0;
    for (int c = 0; c < 3; c++) begin
      check("R12 ready low", req_ready, 0);
      check("R12 valid held", rsp_valid, 1);
      check("R12 data held", rsp_rdata, 8'hFF);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R12 released", {rsp_valid, req_ready}, 2'b01);

    finish_run();
  end
endmodule